// File: doc/BRIEF.md
# Dual-Link Pixel Serializer

This block converts two parallel pixel streams into serial lane bits. One link carries odd pixels and the other carries even pixels. Each pixel has three 6-bit colour components and the horizontal sync, vertical sync and data-enable flags. For each link, the block packs these 21 bits into three 7-bit lane words. It shifts each word out one bit per bit-enable pulse, so a pixel period lasts seven bit slots. A fourth lane on each link carries a repeating clock pattern that is aligned to the word boundary.

Everything runs on one fast clock. A bit-enable input marks the cycles on which the lanes advance, which is seven times the pixel rate. The block raises a strobe in the cycle in which it captures the pixel inputs. The pixel source updates its data when it sees that strobe. The outputs are single-ended bits, ready to go to an external differential driver.

Top module: `dual_link_serializer`

## Requirements
- R1: Lane 0 of each link sends red bits 0 to 5 in slots 0 to 5 and green bit 0 in slot 6. Slot 0 is sent first after a capture.
- R2: Lane 1 of each link sends green bits 1 to 5 in slots 0 to 4, blue bit 0 in slot 5 and blue bit 1 in slot 6.
- R3: Lane 2 of each link sends blue bits 2 to 5 in slots 0 to 3, then horizontal sync in slot 4, vertical sync in slot 5 and data enable in slot 6.
- R4: The clock lane of each link sends 1,1,0,0,0,1,1 over slots 0 to 6 of every word.
- R5: `pix_take` is high, combinationally, exactly when `link_en` and `bit_en` are both high and the link is either in its last slot or has not yet loaded a word since it was enabled. The pixel on the inputs in that cycle is sent starting from slot 0 at the next clock edge. `pix_take` is never high in two consecutive cycles.
- R6: The lanes advance by one slot only on clock edges where `bit_en` is high. While `bit_en` is low, every output holds its value.
- R7: While `link_en` is low, every lane output and `pix_take` are low. After re-enabling, the first cycle with `bit_en` high captures a new pixel.
- R8: The odd and even links carry their own pixel data with identical slot timing. Their clock lanes are always equal.
- R9: After reset, every output is low until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock shared by all lanes |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-slot enable, seven per pixel period |
| link_en | input | 1 | Enables both links; when low, all outputs are forced low |
| odd_r | input | 6 | Odd pixel red, bit 5 is MSB |
| odd_g | input | 6 | Odd pixel green |
| odd_b | input | 6 | Odd pixel blue |
| odd_hs | input | 1 | Odd pixel horizontal sync |
| odd_vs | input | 1 | Odd pixel vertical sync |
| odd_de | input | 1 | Odd pixel data enable |
| even_r | input | 6 | Even pixel red |
| even_g | input | 6 | Even pixel green |
| even_b | input | 6 | Even pixel blue |
| even_hs | input | 1 | Even pixel horizontal sync |
| even_vs | input | 1 | Even pixel vertical sync |
| even_de | input | 1 | Even pixel data enable |
| pix_take | output | 1 | Pixel inputs are captured at the coming edge |
| odd_lane | output | 3 | Odd link data lane bits, index = lane number |
| odd_clk_lane | output | 1 | Odd link clock lane bit |
| even_lane | output | 3 | Even link data lane bits |
| even_clk_lane | output | 1 | Even link clock lane bit |

## Verification
If the slot counter is corrupted, the clock lane pattern drifts off the word boundary. The `pix_take` spacing also leaves the seven-enable rhythm. Both effects appear within one pixel period, at most seven enabled cycles.

A packing or ordering fault puts a wrong bit in a lane slot. It shows in the very first word that exercises that bit. The bench therefore sends walking-one pixels, with complementary data on the two links, so that a crossed bit or a crossed link cannot hide.

A missing clear on disable shows as stale bits in the first slots after `link_en` returns.

// File: rtl/dls_pkg.sv
package dls_pkg;
   localparam int COLOR_W    = 6;
   localparam int SLOT_N     = 7;
   localparam int DATA_LANES = 3;
   localparam int LINKS      = 2;
   localparam int PIX_W      = 3 * COLOR_W + 3;

   typedef struct packed {
      logic [COLOR_W-1:0] red;
      logic [COLOR_W-1:0] green;
      logic [COLOR_W-1:0] blue;
      logic               hsync;
      logic               vsync;
      logic               den;
   } pixel_t;

   typedef logic [SLOT_N-1:0] word_t;
endpackage

// File: rtl/dls_phase_ctrl.sv
module dls_phase_ctrl #(
   parameter int SLOTS = 7,
   localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic          clk_fast,
   input  logic          rst_n,
   input  logic          link_en,
   input  logic          bit_en,
   output logic [PW-1:0] phase_o,
   output logic          load_o
);
   localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

   logic [PW-1:0] phase_q;

   // The idle phase is LAST, so the first enabled slot always loads a word.
   always_ff @(posedge clk_fast) begin
      if (!rst_n || !link_en) begin
         phase_q <= LAST;
      end else if (bit_en) begin
         phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
   end

   assign load_o  = link_en & bit_en & (phase_q == LAST);
   assign phase_o = phase_q;
endmodule

// File: rtl/dls_lane_packer.sv
module dls_lane_packer
   import dls_pkg::*;
(
   input  pixel_t                            pix_i,
   output logic [DATA_LANES-1:0][SLOT_N-1:0] words_o
);
   // Word bit k is transmitted in slot k; slot 0 leaves first.
   always_comb begin
      words_o[0] = {pix_i.green[0], pix_i.red};
      words_o[1] = {pix_i.blue[1:0], pix_i.green[COLOR_W-1:1]};
      words_o[2] = {pix_i.den, pix_i.vsync, pix_i.hsync, pix_i.blue[COLOR_W-1:2]};
   end
endmodule

// File: rtl/dls_shift_lane.sv
module dls_shift_lane #(
   parameter int W = 7
) (
   input  logic         clk_fast,
   input  logic         rst_n,
   input  logic         link_en,
   input  logic         bit_en,
   input  logic         load_i,
   input  logic [W-1:0] word_i,
   output logic         ser_o
);
   logic [W-1:0] sh_q;

   always_ff @(posedge clk_fast) begin
      if (!rst_n || !link_en) begin
         sh_q <= '0;
      end else if (load_i) begin
         sh_q <= word_i;
      end else if (bit_en) begin
         sh_q <= sh_q >> 1;
      end
   end

   assign ser_o = sh_q[0] & link_en;
endmodule

// File: rtl/dual_link_serializer.sv
module dual_link_serializer
   import dls_pkg::*;
#(
   parameter int                COMP_W      = COLOR_W,
   parameter int                SLOTS       = SLOT_N,
   parameter logic [SLOT_N-1:0] CLK_PATTERN = 7'b1100011
) (
   input  logic              clk_fast,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              link_en,
   input  logic [COMP_W-1:0] odd_r,
   input  logic [COMP_W-1:0] odd_g,
   input  logic [COMP_W-1:0] odd_b,
   input  logic              odd_hs,
   input  logic              odd_vs,
   input  logic              odd_de,
   input  logic [COMP_W-1:0] even_r,
   input  logic [COMP_W-1:0] even_g,
   input  logic [COMP_W-1:0] even_b,
   input  logic              even_hs,
   input  logic              even_vs,
   input  logic              even_de,
   output logic              pix_take,
   output logic [2:0]        odd_lane,
   output logic              odd_clk_lane,
   output logic [2:0]        even_lane,
   output logic              even_clk_lane
);
   localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   // The lane packing is fixed to 6-bit colour in 7-slot words.
   if (COMP_W != COLOR_W) begin : g_bad_comp
      $error("COMP_W must equal the packed colour width");
   end
   if (SLOTS != SLOT_N) begin : g_bad_slots
      $error("SLOTS must equal the lane word width");
   end
   if (3 * COMP_W + 3 != DATA_LANES * SLOTS) begin : g_bad_fit
      $error("pixel fields do not fill the data lanes exactly");
   end

   logic [PW-1:0] phase_q;
   logic          load;

   dls_phase_ctrl #(.SLOTS(SLOTS)) u_phase (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .link_en  (link_en),
      .bit_en   (bit_en),
      .phase_o  (phase_q),
      .load_o   (load)
   );

   assign pix_take = load;

   pixel_t pix [LINKS];
   assign pix[0] = {odd_r, odd_g, odd_b, odd_hs, odd_vs, odd_de};
   assign pix[1] = {even_r, even_g, even_b, even_hs, even_vs, even_de};

   logic [LINKS-1:0][DATA_LANES-1:0] lane_bits;
   logic [LINKS-1:0]                 clk_bits;

   for (genvar l = 0; l < LINKS; l++) begin : g_link
      logic [DATA_LANES-1:0][SLOT_N-1:0] words;

      dls_lane_packer u_pack (
         .pix_i   (pix[l]),
         .words_o (words)
      );

      for (genvar k = 0; k < DATA_LANES; k++) begin : g_lane
         dls_shift_lane #(.W(SLOTS)) u_data (
            .clk_fast (clk_fast),
            .rst_n    (rst_n),
            .link_en  (link_en),
            .bit_en   (bit_en),
            .load_i   (load),
            .word_i   (words[k]),
            .ser_o    (lane_bits[l][k])
         );
      end

      dls_shift_lane #(.W(SLOTS)) u_clk (
         .clk_fast (clk_fast),
         .rst_n    (rst_n),
         .link_en  (link_en),
         .bit_en   (bit_en),
         .load_i   (load),
         .word_i   (CLK_PATTERN),
         .ser_o    (clk_bits[l])
      );
   end

   assign odd_lane      = lane_bits[0];
   assign even_lane     = lane_bits[1];
   assign odd_clk_lane  = clk_bits[0];
   assign even_clk_lane = clk_bits[1];
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
   parameter int SLOTS = 7,
   parameter int PW    = 3
) (
   input logic          clk_fast,
   input logic          rst_n,
   input logic          link_en,
   input logic          bit_en,
   input logic          pix_take,
   input logic [2:0]    odd_lane,
   input logic          odd_clk_lane,
   input logic [2:0]    even_lane,
   input logic          even_clk_lane,
   input logic [PW-1:0] phase
);
   AST_DISABLED_LOW: assert property (@(posedge clk_fast) disable iff (!rst_n)
      !link_en |-> (odd_lane == 3'b0 && even_lane == 3'b0 && !odd_clk_lane && !even_clk_lane && !pix_take)); // R7

   AST_TAKE_ISOLATED: assert property (@(posedge clk_fast) disable iff (!rst_n)
      pix_take |=> !pix_take); // R5

   AST_CLK_SLOT0_HIGH: assert property (@(posedge clk_fast) disable iff (!rst_n)
      pix_take |=> (!link_en || (odd_clk_lane && even_clk_lane))); // R4

   AST_CLK_TWIN: assert property (@(posedge clk_fast) disable iff (!rst_n)
      odd_clk_lane == even_clk_lane); // R8

   AST_HOLD_NO_ENABLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (link_en && !bit_en) |=> (!link_en || ($stable(odd_lane) && $stable(even_lane) && $stable(odd_clk_lane)))); // R6

   AST_PHASE_RANGE: assert property (@(posedge clk_fast) disable iff (!rst_n)
      phase < PW'(SLOTS)); // R5
endmodule

bind dual_link_serializer dls_checker #(.SLOTS(SLOTS), .PW(PW)) u_chk (
   .clk_fast      (clk_fast),
   .rst_n         (rst_n),
   .link_en       (link_en),
   .bit_en        (bit_en),
   .pix_take      (pix_take),
   .odd_lane      (odd_lane),
   .odd_clk_lane  (odd_clk_lane),
   .even_lane     (even_lane),
   .even_clk_lane (even_clk_lane),
   .phase         (phase_q)
);

// File: tb/dual_link_serializer_bench.sv
module dual_link_serializer_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic link_en = 1'b0;
   logic [20:0] px_odd = '0;
   logic [20:0] px_even = '0;
   logic pix_take;
   logic [2:0] odd_lane, even_lane;
   logic odd_clk_lane, even_clk_lane;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dual_link_serializer u_dual_link_serializer (
      .clk_fast (clk), .rst_n (rst_n), .bit_en (bit_en), .link_en (link_en),
      .odd_r (px_odd[20:15]), .odd_g (px_odd[14:9]), .odd_b (px_odd[8:3]),
      .odd_hs (px_odd[2]), .odd_vs (px_odd[1]), .odd_de (px_odd[0]),
      .even_r (px_even[20:15]), .even_g (px_even[14:9]), .even_b (px_even[8:3]),
      .even_hs (px_even[2]), .even_vs (px_even[1]), .even_de (px_even[0]),
      .pix_take (pix_take), .odd_lane (odd_lane), .odd_clk_lane (odd_clk_lane),
      .even_lane (even_lane), .even_clk_lane (even_clk_lane)
   );

   // Model state
   int          m_phase = 6;
   bit          m_valid = 0;
   logic [6:0]  m_w [2][4];
   logic [3:0]  prev_out [2];
   bit          prev_hold = 0;

   // Lane words from the slot assignments in R1, R2, R3, R4
   function automatic logic [6:0] lane_word(int lane, logic [20:0] p);
      logic [5:0] r, g, b;
      r = p[20:15]; g = p[14:9]; b = p[8:3];
      case (lane)
         0: return {g[0], r};
         1: return {b[1:0], g[5:1]};
         2: return {p[0], p[1], p[2], b[5:2]};
         default: return 7'b1100011;
      endcase
   endfunction

   function automatic string lane_req(int lane);
      case (lane)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b phase=%0d", req, what, act, exp, m_phase);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic check_outputs();
      logic [3:0] got [2];
      got[0] = {odd_clk_lane, odd_lane};
      got[1] = {even_clk_lane, even_lane};
      for (int l = 0; l < 2; l++) begin
         for (int k = 0; k < 4; k++) begin
            logic e;
            string req;
            e = (link_en && m_valid) ? m_w[l][k][m_phase] : 1'b0;
            req = !link_en ? "R7" : (!m_valid ? "R9" : lane_req(k));
            chk(got[l][k], e, req, $sformatf("link%0d lane%0d", l, k));
            if (prev_hold && link_en)
               chk(got[l][k], prev_out[l][k], "R6", $sformatf("hold link%0d lane%0d", l, k));
         end
      end
      chk(odd_clk_lane, even_clk_lane, "R8", "clock lanes equal");
      prev_out[0] = got[0];
      prev_out[1] = got[1];
   endtask

   task automatic step(input logic en, input logic be, input logic [20:0] po, input logic [20:0] pe);
      logic exp_take;
      @(negedge clk);
      check_outputs();
      prev_hold = en && !be && link_en;
      link_en = en; bit_en = be; px_odd = po; px_even = pe;
      #1;
      exp_take = en && be && (m_phase == 6);
      chk(pix_take, exp_take, en ? "R5" : "R7", "pix_take");
      @(posedge clk);
      if (!en) begin
         m_phase = 6; m_valid = 0;
      end else if (be) begin
         if (m_phase == 6) begin
            m_phase = 0; m_valid = 1;
            for (int k = 0; k < 4; k++) begin
               m_w[0][k] = lane_word(k, po);
               m_w[1][k] = lane_word(k, pe);
            end
         end else begin
            m_phase++;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [20:0] rnd_o, rnd_e;
      void'($urandom(32'd2024));
      for (int l = 0; l < 2; l++) for (int k = 0; k < 4; k++) m_w[l][k] = '0;
      prev_out[0] = '0; prev_out[1] = '0;
      repeat (4) @(negedge clk);
      // R9: outputs low in reset
      chk(|{odd_lane, even_lane, odd_clk_lane, even_clk_lane, pix_take}, 1'b0, "R9", "outputs in reset");
      rst_n = 1'b1;
      // R9: enabled but no bit slot yet, nothing sent
      step(1'b1, 1'b0, 21'h1FFFFF, 21'h1FFFFF);
      step(1'b1, 1'b0, 21'h1FFFFF, 21'h1FFFFF);
      // Corner words: all ones, all zeros
      repeat (7) step(1'b1, 1'b1, 21'h1FFFFF, 21'h000000);
      repeat (7) step(1'b1, 1'b1, 21'h000000, 21'h1FFFFF);
      // Walking one, complementary even link (R1, R2, R3, R8)
      for (int i = 0; i < 21; i++) begin
         for (int s = 0; s < 7; s++) step(1'b1, 1'b1, 21'(1) << i, ~(21'(1) << i));
      end
      // Disable mid-word, re-enable (R7)
      repeat (3) step(1'b1, 1'b1, 21'h0A5A5A, 21'h15A5A5);
      repeat (3) step(1'b0, 1'b1, 21'h1FFFFF, 21'h1FFFFF);
      repeat (10) step(1'b1, 1'b1, 21'h12345, 21'h0FEDC);
      // Random traffic with gapped bit enables (R6)
      for (int c = 0; c < 3000; c++) begin
         logic en, be;
         rnd_o = 21'($urandom);
         rnd_e = 21'($urandom);
         en = ($urandom % 64) != 0;
         be = ($urandom % 4) != 0;
         step(en, be, rnd_o, rnd_e);
      end
      @(negedge clk);
      check_outputs();
      done = 1;
      summary();
      $finish;
   end
endmodule